// File: doc/BRIEF.md
# Cascadable Two-Stage Compare Timer

This block is a programmable interval timer made of a 4-bit up-counter stage and an 8-bit up-counter stage. Each stage has its own compare register. A mode setting arranges the stages in one of three ways. In the first they form a single 12-bit counter. In the second the 4-bit stage acts as a prescaler that clocks the 8-bit stage. In the third the two stages run side by side as independent counters. The counters advance on a count tick. A select input picks the tick from one of five synchronous strobe sources, and one of those sources fires on every cycle.

An action mask decides what happens when the upper (8-bit or 12-bit) counter matches its compare value or overflows. The possible actions are to restart the counter, to flip the timer output, and to raise a one-cycle interrupt. The 4-bit stage also drives a one-cycle pulse each time it restarts, so it can serve as a clock source for other logic. Compare values pass through staging registers, and a new value takes effect only at the next period boundary. Software can therefore retune a running timer without getting a short or a runaway period.

Top module: `cascade_cmp_timer`

## Requirements
- R1: In mode code 0, the stages form one 12-bit counter. The 8-bit stage is the upper part and advances only when the lower stage rolls over from 15. With the match-restart bit set, a compare value x = {upper register, lower register} gives an interrupt every x+1 ticks.
- R2: In mode code 1, the 4-bit stage with compare z divides the ticks by z+1, and the 8-bit stage counts those divided pulses. With the match-restart bit set and 8-bit compare y, the interrupt period is (z+1)*(y+1) ticks.
- R3: In mode codes 2 and 3 (the two codes behave the same), the 8-bit stage counts every tick and gives a period of y+1 ticks with the match-restart bit set. The 4-bit stage runs on its own with a period of z+1 ticks.
- R4: `stage_pulse` is high for one cycle each time the 4-bit stage restarts. In modes 1 to 3 this happens every z+1 ticks. In mode 0 it happens at the roll-over from 15 and at a 12-bit restart.
- R5: The upper counter always wraps through zero after its all-ones value, and this raises an overflow event. With no match restart, the overflow period is 256 ticks in modes 2 and 3, 4096 ticks in mode 0, and 256*(z+1) ticks in mode 1. A match without the restart bit leaves the count running freely.
- R6: `tmr_out` flips once on any cycle with a match event whose match-toggle bit is set or an overflow event whose overflow-toggle bit is set. It never changes otherwise.
- R7: `irq` is high for exactly the cycle after a match event whose match-irq bit is set, or after an overflow event whose overflow-irq bit is set. With both irq bits clear it stays low.
- R8: `tick_sel` codes: 0 means every cycle, 1 means `src_ext`, 2 means `src_tmr_a`, 3 means `src_tmr_b`, 4 means `src_shift`. Codes 5 to 7 give no ticks, and with them the counters do not move.
- R9: Compare registers are staged. A value written while the timer runs is used only after the current period of that stage ends. While `run` is low the staged value is used at once.
- R10: When `run` is low, both counters clear on the next clock and `tmr_out` holds its value. When `rst_n` is asserted, the counters, `tmr_out`, `irq` and `stage_pulse` go to 0.
- R11: Register map on `wr_addr`: 0 is the lower compare (data bits [3:0]), 1 is the upper compare (bits [7:0]), 2 is the mode (bits [1:0]), and 3 is the action mask. Mask bit 0 is match-restart, bit 1 match-toggle, bit 2 match-irq, bit 3 overflow-toggle and bit 4 overflow-irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Timer enable; low clears the counters |
| tick_sel | input | 3 | Count tick source select |
| src_ext | input | 1 | External count strobe |
| src_tmr_a | input | 1 | Strobe from a neighbouring timer |
| src_tmr_b | input | 1 | Strobe from a second neighbouring timer |
| src_shift | input | 1 | Serial shift clock strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| tmr_out | output | 1 | Toggling timer output |
| stage_pulse | output | 1 | One-cycle pulse at each restart of the 4-bit stage |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench aims at the compare value of zero in every mode. There a design that restarts one tick late would give a period of 2 instead of 1, or would stall the interrupt low. It runs the overflow-only masks to confirm that the upper counter wraps at the right width in each mode. A 12-bit cascade that advanced the upper stage on every tick would show up there as a period of 256 instead of 4096. It rewrites a compare value in the middle of a period and expects one old-length period before the new one. A design without staging would cut that period short. It also stops the timer between events, where a design that cleared the output or kept counting would shift the following period.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    MODE_CASC  = 2'd0,
    MODE_PRE   = 2'd1,
    MODE_SPLIT = 2'd2,
    MODE_ALT   = 2'd3
  } cct_mode_e;

  typedef struct packed {
    logic ovf_irq;
    logic ovf_tgl;
    logic mat_irq;
    logic mat_tgl;
    logic mat_rst;
  } cct_mask_t;

  localparam int MASK_W = 5;

  localparam logic [1:0] ADDR_CMP_LO = 2'd0;
  localparam logic [1:0] ADDR_CMP_HI = 2'd1;
  localparam logic [1:0] ADDR_MODE   = 2'd2;
  localparam logic [1:0] ADDR_MASK   = 2'd3;

endpackage

// File: rtl/cct_rst_sync.sv
module cct_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/cct_tick_sel.sv
module cct_tick_sel #(
  parameter int NSRC  = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  src_vec,
  output logic             tick
);

  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == i[SEL_W-1:0]) hit = src_vec[i];
    end
  end

  assign tick = run && hit;

  assert_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (int'(sel) >= NSRC) |-> !tick);

endmodule

// File: rtl/cct_lo_stage.sv
module cct_lo_stage #(
  parameter int LO_W = 4
) (
  input  logic            clk,
  input  logic            rst_sn,
  input  logic            run,
  input  logic            tick,
  input  logic            cascade,
  input  logic            hi_restart,
  input  logic [LO_W-1:0] cmp_stage,
  output logic [LO_W-1:0] lo_cnt,
  output logic [LO_W-1:0] cmp_act,
  output logic            lo_term,
  output logic            lo_wrap
);

  logic [LO_W-1:0] cnt_q, cnt_d;
  logic [LO_W-1:0] act_q, act_d;
  logic            load;

  // terminal count: full roll-over when cascaded, own compare otherwise
  assign lo_term = cascade ? (cnt_q == {LO_W{1'b1}}) : (cnt_q == act_q);
  assign lo_wrap = tick && (lo_term || (cascade && hi_restart));
  assign load    = !run || (cascade ? hi_restart : lo_wrap);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = '0;
    else if (lo_wrap) cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;
    act_d = load ? cmp_stage : act_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign lo_cnt  = cnt_q;
  assign cmp_act = act_q;

  assert_lo_bound_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (run && !cascade && $past(run) && !$past(cascade)) |-> (cnt_q <= act_q));

endmodule

// File: rtl/cct_hi_stage.sv
module cct_hi_stage
  import cct_pkg::*;
#(
  parameter int LO_W = 4,
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_sn,
  input  logic            run,
  input  logic            tick,
  input  cct_mode_e       mode,
  input  cct_mask_t       mask,
  input  logic [LO_W-1:0] lo_cnt,
  input  logic [LO_W-1:0] lo_cmp,
  input  logic            lo_term,
  input  logic [HI_W-1:0] cmp_stage,
  output logic [HI_W-1:0] hi_cnt,
  output logic            match_ev,
  output logic            ovf_ev,
  output logic            restart
);

  logic [HI_W-1:0] cnt_q, cnt_d;
  logic [HI_W-1:0] act_q, act_d;
  logic            adv;
  logic            hi_eq;
  logic            chained;

  assign chained = (mode == MODE_CASC) || (mode == MODE_PRE);
  assign adv     = chained ? (tick && lo_term) : tick;
  assign hi_eq   = (cnt_q == act_q);

  always_comb begin
    if (mode == MODE_CASC) match_ev = tick && hi_eq && (lo_cnt == lo_cmp);
    else                   match_ev = adv && hi_eq;
  end

  assign ovf_ev  = adv && (cnt_q == {HI_W{1'b1}});
  assign restart = (match_ev && mask.mat_rst) || ovf_ev;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = '0;
    else if (restart) cnt_d = '0;
    else if (adv)     cnt_d = cnt_q + 1'b1;
    act_d = (!run || restart) ? cmp_stage : act_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign hi_cnt = cnt_q;

  assert_hi_bound_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (run && $past(run) && mask.mat_rst && $past(mask.mat_rst) &&
     (mode != MODE_CASC) && ($past(mode) != MODE_CASC)) |-> (cnt_q <= act_q));

  assert_adv_only_tick_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(run) && run && (cnt_q != $past(cnt_q))) |-> $past(tick));

endmodule

// File: rtl/cascade_cmp_timer.sv
module cascade_cmp_timer
  import cct_pkg::*;
#(
  parameter int LO_W  = 4,
  parameter int HI_W  = 8,
  parameter int NSRC  = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] tick_sel,
  input  logic             src_ext,
  input  logic             src_tmr_a,
  input  logic             src_tmr_b,
  input  logic             src_shift,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [HI_W-1:0]  wr_data,
  output logic             tmr_out,
  output logic             stage_pulse,
  output logic             irq
);

  logic            rst_sn;
  logic            tick;
  logic [NSRC-1:0] src_vec;

  logic [LO_W-1:0] cmp_lo_q, cmp_lo_d;
  logic [HI_W-1:0] cmp_hi_q, cmp_hi_d;
  cct_mode_e       mode_q, mode_d;
  cct_mask_t       mask_q, mask_d;

  logic tgl_q, tgl_d;
  logic irq_q, irq_d;
  logic pls_q, pls_d;

  logic [LO_W-1:0] lo_cnt, lo_cmp;
  logic [HI_W-1:0] hi_cnt;
  logic            lo_term, lo_wrap;
  logic            match_ev, ovf_ev, hi_restart;
  logic            wr_spare_unused;

  assign wr_spare_unused = ^wr_data;

  cct_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  assign src_vec = {src_shift, src_tmr_b, src_tmr_a, src_ext, 1'b1};

  cct_tick_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_tick (
    .clk(clk), .rst_sn(rst_sn), .run(run), .sel(tick_sel),
    .src_vec(src_vec), .tick(tick)
  );

  cct_lo_stage #(.LO_W(LO_W)) u_lo (
    .clk(clk), .rst_sn(rst_sn), .run(run), .tick(tick),
    .cascade(mode_q == MODE_CASC), .hi_restart(hi_restart),
    .cmp_stage(cmp_lo_q), .lo_cnt(lo_cnt), .cmp_act(lo_cmp),
    .lo_term(lo_term), .lo_wrap(lo_wrap)
  );

  cct_hi_stage #(.LO_W(LO_W), .HI_W(HI_W)) u_hi (
    .clk(clk), .rst_sn(rst_sn), .run(run), .tick(tick),
    .mode(mode_q), .mask(mask_q), .lo_cnt(lo_cnt), .lo_cmp(lo_cmp),
    .lo_term(lo_term), .cmp_stage(cmp_hi_q), .hi_cnt(hi_cnt),
    .match_ev(match_ev), .ovf_ev(ovf_ev), .restart(hi_restart)
  );

  // register file next state
  always_comb begin
    cmp_lo_d = cmp_lo_q;
    cmp_hi_d = cmp_hi_q;
    mode_d   = mode_q;
    mask_d   = mask_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_CMP_LO: cmp_lo_d = wr_data[LO_W-1:0];
        ADDR_CMP_HI: cmp_hi_d = wr_data;
        ADDR_MODE:   mode_d   = cct_mode_e'(wr_data[1:0]);
        default:     mask_d   = cct_mask_t'(wr_data[MASK_W-1:0]);
      endcase
    end
  end

  // output actions next state
  always_comb begin
    tgl_d = tgl_q ^ ((match_ev && mask_q.mat_tgl) || (ovf_ev && mask_q.ovf_tgl));
    irq_d = (match_ev && mask_q.mat_irq) || (ovf_ev && mask_q.ovf_irq);
    pls_d = lo_wrap;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cmp_lo_q <= '0;
      cmp_hi_q <= '0;
      mode_q   <= MODE_CASC;
      mask_q   <= '0;
      tgl_q    <= 1'b0;
      irq_q    <= 1'b0;
      pls_q    <= 1'b0;
    end else begin
      cmp_lo_q <= cmp_lo_d;
      cmp_hi_q <= cmp_hi_d;
      mode_q   <= mode_d;
      mask_q   <= mask_d;
      tgl_q    <= tgl_d;
      irq_q    <= irq_d;
      pls_q    <= pls_d;
    end
  end

  assign tmr_out     = tgl_q;
  assign irq         = irq_q;
  assign stage_pulse = pls_q;

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> ($past(mask_q.mat_irq) || $past(mask_q.ovf_irq)));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !$past(run) |-> $stable(tmr_out));

  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !run |=> (lo_cnt == '0 && hi_cnt == '0));

  assert_pulse_tick_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    stage_pulse |-> $past(tick));

  assert_toggle_cause_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(tmr_out) |-> ($past(mask_q.mat_tgl) || $past(mask_q.ovf_tgl)));

endmodule

// File: tb/cascade_cmp_timer_tb.sv
module cascade_cmp_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [2:0] tick_sel = 3'd0;
  logic       src_ext = 1'b0, src_tmr_a = 1'b0, src_tmr_b = 1'b0, src_shift = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tmr_out, stage_pulse, irq;

  int total = 0;
  int bad = 0;
  int ph = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cascade_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_sel(tick_sel),
    .src_ext(src_ext), .src_tmr_a(src_tmr_a), .src_tmr_b(src_tmr_b),
    .src_shift(src_shift), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tmr_out(tmr_out), .stage_pulse(stage_pulse), .irq(irq)
  );

  // strobe sources: ext every 3rd, a every 2nd, b every 4th, shift every 5th cycle
  initial forever begin
    @(negedge clk);
    ph++;
    src_ext   = (ph % 3 == 0);
    src_tmr_a = (ph % 2 == 0);
    src_tmr_b = (ph % 4 == 0);
    src_shift = (ph % 5 == 0);
  end

  // fields: sel[39:37] mode[36:35] lo[34:31] hi[30:23] mask[22:18] irq_per[17:5] lo_per[4:0]
  localparam int NV = 16;
  localparam logic [39:0] VEC [NV] = '{
    {3'd0, 2'd0, 4'd3,  8'h12, 5'b00101, 13'd292,  5'd0},   // R1
    {3'd0, 2'd0, 4'd15, 8'h00, 5'b00101, 13'd16,   5'd16},  // R1 R4
    {3'd0, 2'd0, 4'd0,  8'h00, 5'b00101, 13'd1,    5'd1},   // R1 zero
    {3'd0, 2'd1, 4'd2,  8'h04, 5'b00101, 13'd15,   5'd3},   // R2
    {3'd0, 2'd1, 4'd0,  8'h00, 5'b00101, 13'd1,    5'd1},   // R2 zero
    {3'd0, 2'd2, 4'd4,  8'h09, 5'b00101, 13'd10,   5'd5},   // R3
    {3'd0, 2'd2, 4'd0,  8'h00, 5'b00101, 13'd1,    5'd1},   // R3 zero
    {3'd0, 2'd3, 4'd6,  8'h06, 5'b00101, 13'd7,    5'd7},   // R3 alias code
    {3'd0, 2'd2, 4'd1,  8'h07, 5'b10000, 13'd256,  5'd2},   // R5
    {3'd0, 2'd0, 4'd0,  8'h00, 5'b10000, 13'd4096, 5'd16},  // R5
    {3'd0, 2'd1, 4'd1,  8'h00, 5'b10000, 13'd512,  5'd2},   // R5
    {3'd0, 2'd2, 4'd3,  8'h05, 5'b00100, 13'd256,  5'd4},   // R5 match free-run
    {3'd1, 2'd2, 4'd0,  8'h04, 5'b00101, 13'd15,   5'd3},   // R8
    {3'd2, 2'd2, 4'd0,  8'h04, 5'b00101, 13'd10,   5'd2},   // R8
    {3'd3, 2'd2, 4'd0,  8'h04, 5'b00101, 13'd20,   5'd4},   // R8
    {3'd4, 2'd2, 4'd0,  8'h04, 5'b00101, 13'd25,   5'd5}    // R8
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // count negedges until the chosen output (0 irq, 1 stage_pulse) is seen high; 0 on timeout
  task automatic count_until(input int which, input int limit, output int n);
    logic hit;
    n = 0;
    hit = 1'b0;
    while (!hit && n < limit) begin
      @(negedge clk);
      n++;
      hit = (which == 0) ? irq : stage_pulse;
    end
    if (!hit) n = 0;
  endtask

  task automatic setup(input logic [2:0] s, input logic [1:0] m, input logic [3:0] lo,
                       input logic [7:0] hi, input logic [4:0] mk);
    run = 1'b0;
    tick_sel = s;
    wr(2'd0, {4'd0, lo});  // R11 lower compare
    wr(2'd1, hi);          // R11 upper compare
    wr(2'd2, {6'd0, m});   // R11 mode
    wr(2'd3, {3'd0, mk});  // R11 mask
    @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int t;
    logic prev;
    logic held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset tmr_out", int'(tmr_out), 0);
    chk("R10 reset irq", int'(irq), 0);
    chk("R10 reset stage_pulse", int'(stage_pulse), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      setup(v[39:37], v[36:35], v[34:31], v[30:23], v[22:18]);
      run = 1'b1;
      count_until(0, 6000, n);
      count_until(0, 6000, n);
      chk($sformatf("R1/R2/R3/R5/R8 irq period vec%0d", i), n, int'(v[17:5]));
      if (v[4:0] != 5'd0) begin
        count_until(1, 6000, n);
        count_until(1, 6000, n);
        chk($sformatf("R4 stage_pulse period vec%0d", i), n, int'(v[4:0]));
      end
    end

    // R8: unused select code gives no ticks
    setup(3'd6, 2'd2, 4'd0, 8'd0, 5'b00111);
    run = 1'b1;
    prev = tmr_out;
    count_until(0, 100, n);
    chk("R8 no irq with code 6", n, 0);
    count_until(1, 50, n);
    chk("R8 no stage_pulse with code 6", n, 0);
    chk("R8 tmr_out unchanged with code 6", int'(tmr_out), int'(prev));

    // R6 R7: toggle without irq, mode 2, y=3
    setup(3'd0, 2'd2, 4'd0, 8'd3, 5'b00011);
    prev = tmr_out;
    run = 1'b1;
    t = 0;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tmr_out != prev) t++;
      if (irq) n++;
      prev = tmr_out;
    end
    chk("R6 toggles in 40 ticks", t, 10);
    chk("R7 irq masked off", n, 0);

    // R6: no toggle bit set, tmr_out stays
    setup(3'd0, 2'd2, 4'd0, 8'd3, 5'b00101);
    prev = tmr_out;
    run = 1'b1;
    t = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tmr_out != prev) t++;
      prev = tmr_out;
    end
    chk("R6 no toggle without mask bit", t, 0);

    // R9: staged compare rewrite while running
    setup(3'd0, 2'd2, 4'd0, 8'd9, 5'b00101);
    run = 1'b1;
    count_until(0, 100, n);
    wr(2'd1, 8'd4);
    count_until(0, 100, n);
    chk("R9 current period keeps old compare", n + 1, 10);
    count_until(0, 100, n);
    chk("R9 next period uses new compare", n, 5);

    // R10: stop holds tmr_out, restart from zero
    setup(3'd0, 2'd2, 4'd0, 8'd9, 5'b00111);
    run = 1'b1;
    count_until(0, 100, n);
    held = tmr_out;
    run = 1'b0;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tmr_out != held || irq) n++;
    end
    chk("R10 tmr_out held and no irq while stopped", n, 0);
    run = 1'b1;
    count_until(0, 100, n);
    chk("R10 restart period from cleared counters", n, 10);

    // R10: asynchronous reset in the middle of a run
    run = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async reset tmr_out", int'(tmr_out), 0);
    chk("R10 async reset irq", int'(irq), 0);
    run = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 after reset stage_pulse", int'(stage_pulse), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule